// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block holds the control and status registers of an ECC memory controller. A 32-bit register bus selects one of nine word registers through address bits [5:2]. In index order they are: enable (0), delay (1), fault status (2), video configuration (3), fault address 0 (4), fault address 1 (5), diagnostic (6), event count 0 (7) and event count 1 (8). The block stores the delay and configuration fields but does not use them.

A static parameter `VARIANT` (0, 1 or 2) selects one of three chip variants. The variant decides which enable bits a write can set, the identity field forced into the enable register, and which enable fields survive a warm reset. An error-capture sideband port loads the two fault address registers and updates the fault status. From that port the block raises a level interrupt. Any bus write to the fault status register clears the interrupt.

Variant 0 also has a four-byte diagnostic window on its own byte port. The window ignores all address bits above the lowest two.

Top module: `memctl_csr`

## Requirements
- R1: After cold reset (`cold_rst_n` low), the registers read as follows. Enable holds only the identity value (VARIANT in bits [31:28], zeros elsewhere). Delay reads 0x00000020 and fault address 0 reads 0x07C00000. Every other register reads 0, the interrupt is low and the diagnostic bytes are 0.
- R2: A write to the enable register works by variant. Variant 0 stores `data & 0x00000103`. Variants 1 and 2 store `(data & 0x00000BFF) | identity`. Bits [27:24] therefore always read 0 and bits [31:28] always read VARIANT.
- R3: A write to the delay register stores `data & 0x7FFFFFFF`, so bit 31 always reads 0.
- R4: A bus write to the fault status register stores the written value and drives `irq` low from the next cycle on, unless an error is captured in the same cycle.
- R5: An error capture (`err_valid`) works as follows. It sets fault status bit 3 when `err_ue` is 1, or bit 0 when `err_ue` is 0. It writes `err_syndrome` into bits [15:8] and loads fault addresses 0 and 1 from `err_addr0` and `err_addr1`. If bit 0 was already set before the capture, it also sets bit 16.
- R6: A captured uncorrectable error always raises `irq`. A captured correctable error raises `irq` only when enable bit 1 is 1. Once raised, `irq` stays high until a fault status write clears it.
- R7: A warm reset (`rst_n` low at a clock edge) sets the non-enable registers and `irq` as in R1. The enable register keeps only bit 8 on variant 0, and keeps bits [31:24], [9:2] and 11 on variants 1 and 2. The diagnostic window bytes are left unchanged.
- R8: Bus writes to fault address 0 and 1 have no effect. Only an error capture changes these registers.
- R9: Video configuration, diagnostic, event count 0 and event count 1 each store a full 32-bit value in their own storage. A write to one leaves the others unchanged.
- R10: The block accepts only full-word accesses (`bus_be` = 4'hF). A partial write has no effect and a partial read returns 0. Indices 9 to 15 read 0 and ignore writes.
- R11: On variant 0, the byte window stores four bytes indexed by `diag_addr[1:0]`. A read returns the stored byte. On variants 1 and 2, the window always reads 0.
- R12: When a fault status write and an error capture happen in the same cycle, the capture is applied on top of the written value. Bit 16 then depends on bit 0 of the written value, and `irq` follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous warm reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [5:2] select the register |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| err_valid | input | 1 | Error capture strobe |
| err_ue | input | 1 | 1 = uncorrectable, 0 = correctable |
| err_syndrome | input | SYN_W | Syndrome of the captured error |
| err_addr0 | input | 32 | Value loaded into fault address 0 |
| err_addr1 | input | 32 | Value loaded into fault address 1 |
| diag_sel | input | 1 | Byte window access strobe |
| diag_wr | input | 1 | 1 = write, 0 = read |
| diag_addr | input | DIAG_AW | Byte window address, taken modulo four |
| diag_wdata | input | 8 | Byte window write data |
| diag_rdata | output | 8 | Byte window read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs one instance of each variant side by side, so a mask or identity value taken from the wrong variant shows up as a readback mismatch on one instance and not the others. It captures a correctable error with interrupts disabled and then enabled. A design that ignores enable bit 1 would raise the interrupt too early or never. Back-to-back captures and a capture in the same cycle as a fault status write check the multiple-error bit: a design that merges the capture with the old value instead of the written one gets bit 16 wrong. Warm resets after enable writes that set all bits catch a keep mask that drops the SIMM or refresh fields. Partial-strobe writes, writes to the fault address registers and writes to unmapped indices catch a design that stores where it must not.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

    localparam int unsigned IDX_W    = 4;
    localparam int unsigned IDX_LO   = 2;
    localparam int unsigned NUM_REGS = 9;

    typedef enum logic [IDX_W-1:0] {
        IX_EN  = 4'd0,
        IX_DLY = 4'd1,
        IX_FSR = 4'd2,
        IX_VID = 4'd3,
        IX_FA0 = 4'd4,
        IX_FA1 = 4'd5,
        IX_DGN = 4'd6,
        IX_EC0 = 4'd7,
        IX_EC1 = 4'd8
    } reg_idx_e;

    localparam logic [31:0] DLY_RST   = 32'h0000_0020;
    localparam logic [31:0] FA0_RST   = 32'h07C0_0000;
    localparam logic [31:0] DLY_WMASK = 32'h7FFF_FFFF;

    localparam int unsigned FSR_CE     = 0;
    localparam int unsigned FSR_UE     = 3;
    localparam int unsigned FSR_SYN_LO = 8;
    localparam int unsigned FSR_ME     = 16;
    localparam int unsigned EN_CE_IRQ  = 1;

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] dly;
        logic [31:0] fsr;
        logic [31:0] vid;
        logic [31:0] fa0;
        logic [31:0] fa1;
        logic [31:0] dgn;
        logic [31:0] ec0;
        logic [31:0] ec1;
        logic        irq;
    } csr_state_t;

    function automatic logic [31:0] ident_of(input int unsigned variant);
        logic [31:0] v;
        v = '0;
        v[31:28] = 4'(variant);
        return v;
    endfunction

endpackage

// File: rtl/memctl_en_policy.sv
module memctl_en_policy #(
    parameter int unsigned VARIANT = 0
) (
    output logic [31:0] wr_mask,
    output logic [31:0] keep_mask
);
    generate
        if (VARIANT == 0) begin : g_base
            assign wr_mask   = 32'h0000_0103;
            assign keep_mask = 32'h0000_0100;
        end else begin : g_ext
            assign wr_mask   = 32'h0000_0BFF;
            assign keep_mask = 32'hFF00_0BFC;
        end
    endgenerate
endmodule

// File: rtl/memctl_fault_merge.sv
module memctl_fault_merge
    import memctl_pkg::*;
#(
    parameter int unsigned SYN_W = 8
) (
    input  logic [31:0]      base,
    input  logic             cap,
    input  logic             ue,
    input  logic [SYN_W-1:0] syn,
    output logic [31:0]      merged
);
    always_comb begin
        merged = base;
        if (cap) begin
            if (ue) begin
                merged[FSR_UE] = 1'b1;
            end else begin
                merged[FSR_CE] = 1'b1;
            end
            merged[FSR_SYN_LO +: SYN_W] = syn;
            if (base[FSR_CE]) begin
                merged[FSR_ME] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/memctl_diag_win.sv
module memctl_diag_win #(
    parameter int unsigned VARIANT = 0,
    parameter int unsigned DEPTH   = 4,
    parameter int unsigned AW      = 8
) (
    input  logic          clk,
    input  logic          cold_rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int unsigned SEL_W = $clog2(DEPTH);

    generate
        if (VARIANT == 0) begin : g_win
            logic [7:0]       mem_q [DEPTH];
            logic [7:0]       mem_d [DEPTH];
            logic [SEL_W-1:0] slot;
            logic             unused_hi;

            assign slot      = addr[SEL_W-1:0];
            assign unused_hi = ^addr[AW-1:SEL_W];

            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem_d[i] = mem_q[i];
                end
                if (sel && wr) begin
                    mem_d[slot] = wdata;
                end
            end

            always_ff @(posedge clk or negedge cold_rst_n) begin
                if (!cold_rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem_q[i] <= mem_d[i];
                    end
                end
            end

            assign rdata = (sel && !wr) ? mem_q[slot] : 8'h00;
        end else begin : g_none
            logic unused_in;
            assign unused_in = ^{clk, cold_rst_n, sel, wr, addr, wdata};
            assign rdata     = 8'h00;
        end
    endgenerate
endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
    import memctl_pkg::*;
#(
    parameter int unsigned VARIANT    = 0,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned SYN_W      = 8,
    parameter int unsigned DIAG_DEPTH = 4,
    parameter int unsigned DIAG_AW    = 8
) (
    input  logic               clk,
    input  logic               cold_rst_n,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               err_valid,
    input  logic               err_ue,
    input  logic [SYN_W-1:0]   err_syndrome,
    input  logic [31:0]        err_addr0,
    input  logic [31:0]        err_addr1,
    input  logic               diag_sel,
    input  logic               diag_wr,
    input  logic [DIAG_AW-1:0] diag_addr,
    input  logic [7:0]         diag_wdata,
    output logic [7:0]         diag_rdata,
    output logic               irq
);
    localparam logic [31:0] IDENT = ident_of(VARIANT);

    csr_state_t       s_q, s_d;
    logic [31:0]      wr_mask, keep_mask;
    logic [IDX_W-1:0] acc_idx;
    logic             full_word, wr_ok, rd_ok, fsr_wr;
    logic [31:0]      fsr_base, fsr_merged;
    logic             unused_lsb;

    assign acc_idx    = bus_addr[IDX_LO +: IDX_W];
    assign unused_lsb = ^bus_addr[IDX_LO-1:0];
    assign full_word  = (bus_be == 4'hF);
    assign wr_ok      = bus_sel && bus_wr && full_word;
    assign rd_ok      = bus_sel && !bus_wr && full_word;
    assign fsr_wr     = wr_ok && (acc_idx == IX_FSR);
    assign fsr_base   = fsr_wr ? bus_wdata : s_q.fsr;

    memctl_en_policy #(.VARIANT(VARIANT)) u_policy (
        .wr_mask   (wr_mask),
        .keep_mask (keep_mask)
    );

    memctl_fault_merge #(.SYN_W(SYN_W)) u_merge (
        .base   (fsr_base),
        .cap    (err_valid),
        .ue     (err_ue),
        .syn    (err_syndrome),
        .merged (fsr_merged)
    );

    memctl_diag_win #(
        .VARIANT (VARIANT),
        .DEPTH   (DIAG_DEPTH),
        .AW      (DIAG_AW)
    ) u_diag (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .sel        (diag_sel),
        .wr         (diag_wr),
        .addr       (diag_addr),
        .wdata      (diag_wdata),
        .rdata      (diag_rdata)
    );

    always_comb begin
        s_d = s_q;
        if (wr_ok) begin
            case (acc_idx)
                IX_EN:   s_d.en  = (bus_wdata & wr_mask) | IDENT;
                IX_DLY:  s_d.dly = bus_wdata & DLY_WMASK;
                IX_FSR:  s_d.irq = 1'b0;
                IX_VID:  s_d.vid = bus_wdata;
                IX_DGN:  s_d.dgn = bus_wdata;
                IX_EC0:  s_d.ec0 = bus_wdata;
                IX_EC1:  s_d.ec1 = bus_wdata;
                default: ;
            endcase
        end
        s_d.fsr = fsr_merged;
        if (err_valid) begin
            s_d.fa0 = err_addr0;
            s_d.fa1 = err_addr1;
            if (err_ue || s_q.en[EN_CE_IRQ]) begin
                s_d.irq = 1'b1;
            end
        end
        if (!rst_n) begin
            s_d.en  = (s_q.en & keep_mask) | IDENT;
            s_d.dly = DLY_RST;
            s_d.fsr = '0;
            s_d.vid = '0;
            s_d.fa0 = FA0_RST;
            s_d.fa1 = '0;
            s_d.dgn = '0;
            s_d.ec0 = '0;
            s_d.ec1 = '0;
            s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            s_q.en  <= IDENT;
            s_q.dly <= DLY_RST;
            s_q.fsr <= '0;
            s_q.vid <= '0;
            s_q.fa0 <= FA0_RST;
            s_q.fa1 <= '0;
            s_q.dgn <= '0;
            s_q.ec0 <= '0;
            s_q.ec1 <= '0;
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (acc_idx)
                IX_EN:   bus_rdata = s_q.en;
                IX_DLY:  bus_rdata = s_q.dly;
                IX_FSR:  bus_rdata = s_q.fsr;
                IX_VID:  bus_rdata = s_q.vid;
                IX_FA0:  bus_rdata = s_q.fa0;
                IX_FA1:  bus_rdata = s_q.fa1;
                IX_DGN:  bus_rdata = s_q.dgn;
                IX_EC0:  bus_rdata = s_q.ec0;
                IX_EC1:  bus_rdata = s_q.ec1;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = s_q.irq;

endmodule

// File: rtl/memctl_csr_chk.sv
module memctl_csr_chk #(
    parameter int unsigned VARIANT = 0
) (
    input logic        clk,
    input logic        cold_rst_n,
    input logic        rst_n,
    input logic        err_valid,
    input logic        err_ue,
    input logic        fsr_wr,
    input logic [31:0] en_q,
    input logic [31:0] dly_q,
    input logic [31:0] fsr_q,
    input logic [31:0] fa0_q,
    input logic [31:0] fa1_q,
    input logic        irq
);
    localparam logic [7:0] ID_BYTE = {4'(VARIANT), 4'h0};

    AST_ID_FIELD_FIXED: assert property (@(posedge clk) disable iff (!cold_rst_n)
        en_q[31:24] == ID_BYTE); // R2

    AST_DLY_TOP_CLEAR: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !dly_q[31]); // R3

    AST_FSR_WR_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (rst_n && fsr_wr && !err_valid) |=> !irq); // R4

    AST_ME_ON_REPEAT: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (rst_n && err_valid && !fsr_wr && fsr_q[0]) |=> fsr_q[16]); // R5

    AST_UE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (rst_n && err_valid && err_ue) |=> irq); // R6

    AST_CE_MASKED: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (rst_n && err_valid && !err_ue && !en_q[1] && !irq) |=> !irq); // R6

    AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (rst_n && !err_valid) |=> ($stable(fa0_q) && $stable(fa1_q))); // R8

endmodule

bind memctl_csr memctl_csr_chk #(.VARIANT(VARIANT)) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .rst_n      (rst_n),
    .err_valid  (err_valid),
    .err_ue     (err_ue),
    .fsr_wr     (fsr_wr),
    .en_q       (s_q.en),
    .dly_q      (s_q.dly),
    .fsr_q      (s_q.fsr),
    .fa0_q      (s_q.fa0),
    .fa1_q      (s_q.fa1),
    .irq        (irq)
);

// File: tb/sim_memctl_csr.sv
`timescale 1ns/1ps
module sim_memctl_csr;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        cold_rst_n, rst_n;
    logic        b_sel, b_wr;
    logic [5:0]  b_addr;
    logic [3:0]  b_be;
    logic [31:0] b_wd;
    logic        e_v, e_ue;
    logic [7:0]  e_syn;
    logic [31:0] e_a0, e_a1;
    logic        d_sel, d_wr;
    logic [7:0]  d_addr, d_wd;
    logic [31:0] rd  [3];
    logic [7:0]  drd [3];
    logic        irq_o [3];

    memctl_csr #(.VARIANT(1)) u0 (.clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
        .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr), .bus_be(b_be), .bus_wdata(b_wd),
        .bus_rdata(rd[0]), .err_valid(e_v), .err_ue(e_ue), .err_syndrome(e_syn),
        .err_addr0(e_a0), .err_addr1(e_a1), .diag_sel(d_sel), .diag_wr(d_wr),
        .diag_addr(d_addr), .diag_wdata(d_wd), .diag_rdata(drd[0]), .irq(irq_o[0]));
    memctl_csr #(.VARIANT(0)) u1 (.clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
        .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr), .bus_be(b_be), .bus_wdata(b_wd),
        .bus_rdata(rd[1]), .err_valid(e_v), .err_ue(e_ue), .err_syndrome(e_syn),
        .err_addr0(e_a0), .err_addr1(e_a1), .diag_sel(d_sel), .diag_wr(d_wr),
        .diag_addr(d_addr), .diag_wdata(d_wd), .diag_rdata(drd[1]), .irq(irq_o[1]));
    memctl_csr #(.VARIANT(2)) u2 (.clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
        .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr), .bus_be(b_be), .bus_wdata(b_wd),
        .bus_rdata(rd[2]), .err_valid(e_v), .err_ue(e_ue), .err_syndrome(e_syn),
        .err_addr0(e_a0), .err_addr1(e_a1), .diag_sel(d_sel), .diag_wr(d_wr),
        .diag_addr(d_addr), .diag_wdata(d_wd), .diag_rdata(drd[2]), .irq(irq_o[2]));

    int nchk = 0;
    int nerr = 0;
    logic [31:0] m  [3][9];
    logic        mi [3];
    logic [7:0]  md [4];

    function automatic int var_of(input int i);
        return (i == 0) ? 1 : ((i == 1) ? 0 : 2);
    endfunction
    function automatic logic [31:0] ident(input int i);
        return {4'(var_of(i)), 28'h0};
    endfunction
    function automatic logic [31:0] wmask(input int i);
        return (var_of(i) == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction
    function automatic logic [31:0] kmask(input int i);
        return (var_of(i) == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction
    function automatic string tag_of(input logic [3:0] idx);
        case (idx)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R5";
            4'd4, 4'd5: return "R8";
            4'd3, 4'd6, 4'd7, 4'd8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset(input bit cold);
        for (int i = 0; i < 3; i++) begin
            m[i][0] = cold ? ident(i) : ((m[i][0] & kmask(i)) | ident(i));
            m[i][1] = 32'h20;
            m[i][2] = 0; m[i][3] = 0;
            m[i][4] = 32'h07C0_0000;
            m[i][5] = 0; m[i][6] = 0; m[i][7] = 0; m[i][8] = 0;
            mi[i] = 1'b0;
        end
        if (cold) for (int k = 0; k < 4; k++) md[k] = 8'h00;
    endtask

    task automatic idle();
        b_sel = 0; b_wr = 0; b_addr = 0; b_be = 0; b_wd = 0;
        e_v = 0; e_ue = 0; e_syn = 0; e_a0 = 0; e_a1 = 0;
        d_sel = 0; d_wr = 0; d_addr = 0; d_wd = 0;
    endtask

    task automatic bus_op(input bit sel, input bit wr, input logic [3:0] idx, input logic [3:0] be,
                          input logic [31:0] d, input bit cap, input bit ue, input logic [7:0] syn,
                          input logic [31:0] a0, input logic [31:0] a1, input string tag);
        string t;
        bit    fw;
        t = (tag == "") ? tag_of(idx) : tag;
        if (be != 4'hF && tag == "") t = "R10";
        @(negedge clk);
        b_sel = sel; b_wr = wr; b_addr = {idx, 2'b00}; b_be = be; b_wd = d;
        e_v = cap; e_ue = ue; e_syn = syn; e_a0 = a0; e_a1 = a1;
        #1;
        for (int i = 0; i < 3; i++) begin
            logic [31:0] exp;
            exp = (sel && !wr && be == 4'hF && idx < 9) ? m[i][idx] : 32'h0;
            if (sel && !wr) check(t, rd[i], exp);
        end
        @(posedge clk);
        #1;
        fw = sel && wr && be == 4'hF && idx == 4'd2;
        for (int i = 0; i < 3; i++) begin
            logic [31:0] base, old_en;
            old_en = m[i][0];
            base   = m[i][2];
            if (sel && wr && be == 4'hF) begin
                case (idx)
                    4'd0: m[i][0] = (d & wmask(i)) | ident(i);
                    4'd1: m[i][1] = d & 32'h7FFF_FFFF;
                    4'd2: begin base = d; mi[i] = 1'b0; end
                    4'd3, 4'd6, 4'd7, 4'd8: m[i][idx] = d;
                    default: ;
                endcase
            end
            if (cap) begin
                bit me;
                me = base[0];
                if (ue) base[3] = 1'b1; else base[0] = 1'b1;
                base[15:8] = syn;
                if (me) base[16] = 1'b1;
                m[i][4] = a0; m[i][5] = a1;
                if (ue || old_en[1]) mi[i] = 1'b1;
            end
            m[i][2] = base;
            check(fw ? (cap ? "R12" : "R4") : "R6", {31'h0, irq_o[i]}, {31'h0, mi[i]});
        end
        idle();
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [31:0] d);
        bus_op(1, 1, idx, 4'hF, d, 0, 0, 0, 0, 0, "");
    endtask
    task automatic rd_reg(input logic [3:0] idx, input string tag);
        bus_op(1, 0, idx, 4'hF, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic capture(input bit ue, input logic [7:0] syn, input logic [31:0] a0, input logic [31:0] a1);
        bus_op(0, 0, 0, 0, 0, 1, ue, syn, a0, a1, "");
    endtask
    task automatic check_all(input string tag);
        for (int k = 0; k < 9; k++) rd_reg(4'(k), tag);
    endtask

    task automatic diag_op(input bit wr, input logic [7:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        d_sel = 1; d_wr = wr; d_addr = a; d_wd = d;
        #1;
        if (!wr) begin
            check(tag, {24'h0, drd[1]}, {24'h0, md[a[1:0]]});
            check("R11", {24'h0, drd[0]}, 32'h0);
            check("R11", {24'h0, drd[2]}, 32'h0);
        end
        @(posedge clk);
        #1;
        if (wr) md[a[1:0]] = d;
        idle();
    endtask

    task automatic warm_reset();
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #1;
        rst_n = 1;
        model_reset(0);
        for (int i = 0; i < 3; i++) check("R7", {31'h0, irq_o[i]}, 32'h0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 1;
        cold_rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        cold_rst_n = 1;
        model_reset(1);
        for (int i = 0; i < 3; i++) check("R1", {31'h0, irq_o[i]}, 32'h0);
        check_all("R1");
        for (int k = 0; k < 4; k++) diag_op(0, 8'(k), 0, "R1");

        wr_reg(0, 32'hFFFF_FFFF); rd_reg(0, "R2");
        wr_reg(0, 32'h5A5A_5A5A); rd_reg(0, "R2");
        wr_reg(1, 32'hFFFF_FFFF); rd_reg(1, "R3");
        wr_reg(4, 32'hDEAD_BEEF); wr_reg(5, 32'h1234_5678);
        rd_reg(4, "R8"); rd_reg(5, "R8");

        wr_reg(0, 32'h0000_0001);
        capture(0, 8'h5A, 32'hA000_0001, 32'hB000_0002);
        rd_reg(2, "R5"); rd_reg(4, "R5"); rd_reg(5, "R5");
        capture(0, 8'h33, 32'h0, 32'h1);
        rd_reg(2, "R5");
        wr_reg(2, 32'h0);
        capture(1, 8'hC3, 32'h11, 32'h22);
        rd_reg(2, "R6");
        wr_reg(2, 32'h0);
        bus_op(1, 1, 4'd2, 4'hF, 32'h0000_0001, 1, 0, 8'h77, 32'h5, 32'h6, "");
        rd_reg(2, "R12");
        bus_op(1, 1, 4'd2, 4'hF, 32'h0, 1, 1, 8'h01, 32'h7, 32'h8, "");
        rd_reg(2, "R12");
        wr_reg(2, 32'h0);
        wr_reg(0, 32'h0000_0002);
        capture(0, 8'h10, 32'h9, 32'hA);
        wr_reg(2, 32'h0);

        wr_reg(3, 32'h0BAD_CAFE);
        bus_op(1, 1, 4'd3, 4'h3, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R10");
        bus_op(1, 0, 4'd3, 4'h7, 0, 0, 0, 0, 0, 0, "R10");
        rd_reg(3, "R10");
        bus_op(1, 1, 4'd12, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R10");
        rd_reg(12, "R10");
        wr_reg(7, 32'h1111_1111); wr_reg(8, 32'h2222_2222); wr_reg(6, 32'h3333_3333);
        rd_reg(7, "R9"); rd_reg(8, "R9"); rd_reg(6, "R9");

        diag_op(1, 8'h05, 8'hA5, "R11");
        diag_op(1, 8'hFE, 8'h3C, "R11");
        diag_op(0, 8'h01, 0, "R11");
        diag_op(0, 8'h42, 0, "R11");

        wr_reg(0, 32'hFFFF_FFFF);
        wr_reg(3, 32'h55);
        warm_reset();
        check_all("R7");
        diag_op(0, 8'h01, 0, "R7");

        for (int n = 0; n < 500; n++) begin
            int unsigned kind;
            logic [3:0] idx, be;
            kind = $urandom % 16;
            idx  = 4'($urandom % 16);
            be   = (($urandom % 8) == 0) ? 4'($urandom % 15) : 4'hF;
            if (kind < 6) begin
                bus_op(1, 1, idx, be, $urandom, 0, 0, 0, 0, 0, "");
            end else if (kind < 10) begin
                bus_op(1, 0, idx, be, 0, 0, 0, 0, 0, 0, "");
            end else if (kind < 13) begin
                bit both;
                both = ($urandom % 2) == 1;
                bus_op(both, both, 4'd2, 4'hF, $urandom, 1, ($urandom % 3) == 0,
                       8'($urandom), $urandom, $urandom, both ? "R12" : "");
            end else if (kind < 15) begin
                diag_op(($urandom % 2) == 1, 8'($urandom), 8'($urandom), "R11");
            end else if (($urandom % 4) == 0) begin
                warm_reset();
            end else begin
                rd_reg(idx, "");
            end
        end
        check_all("");
        finish_run();
    end

endmodule